// File: doc/BRIEF.md
# T1 Channel and Link Strobe Generator

This block turns the position counters of a T1 framer (the bit position inside the 193-bit frame and the frame number inside the multiframe) into timing strobes for a serial backplane. It drives a shared clock output and a shared marker output, and the meaning of both depends on a mode select.

In channel mode the clock output pulses during the least significant bit of each of the 24 eight-bit channels. The marker output follows a 24-bit per-channel mask, so downstream logic can gate a serial controller to a subset of timeslots. In link mode the clock output becomes a slow demand clock for the overhead data link. It runs at 4 kHz for the extended superframe data link or for the D4 signaling-framing bits, and at 2 kHz for the reduced-rate variant. A one-cycle strobe marks the overhead bit to sample, and the marker output flags the last bit time before a link-bearing frame. A receive path uses that flag to present the link bit one clock early.

Every output is registered, so it reflects the counters and mode inputs sampled at the previous rising edge of the line clock.

Top module: `t1_slot_timer`

## Requirements
- R1: While `rst_n` is low, `out_clk`, `out_blk` and `link_stb` are all low, whatever the other inputs are.
- R2: In channel mode (`link_sel`=0), `out_clk` is high one clock after `bit_pos` is 8, 16, ..., 192 (the last bit of each channel). It is low after every other position, including the framing bit at position 0.
- R3: In channel mode, `out_blk` one clock after `bit_pos` = p, with 1 ≤ p ≤ 192, equals `chan_mask[(p-1)/8]`. Mask bit n governs channel n+1, and channel 1 occupies positions 1 to 8. After position 0, `out_blk` is low.
- R4: In channel mode, `link_stb` stays low.
- R5: In link mode with `esf_mode`=1 and `half_rate`=0, the link frames are those with even `frame_num` (0-based, so frames 1, 3, 5, ... counting from one). `out_clk` is high one clock after `bit_pos` < 96 in a link frame, and low otherwise.
- R6: In link mode with `esf_mode`=1 and `half_rate`=1, the link frames are those with `frame_num` a multiple of 4. `out_clk` follows the R5 rule for those frames only.
- R7: In link mode with `esf_mode`=0 (12-frame D4), the link frames are those with odd `frame_num`, and `half_rate` has no effect. `out_clk` follows the R5 rule.
- R8: In link mode, `link_stb` is high one clock after `bit_pos` = 0 in a link frame, and low otherwise.
- R9: In link mode, `out_blk` is high one clock after `bit_pos` = 192 when the next frame is a link frame. The frame number wraps from 23 to 0 in the 24-frame mode and from 11 to 0 in D4.
- R10: A `bit_pos` above 192, or a `frame_num` at or beyond the frame count of the selected mode, produces no `out_clk`, `out_blk` or `link_stb` pulse in link mode. A `bit_pos` above 192 produces none in channel mode either.
- R11: Outputs change only at a rising edge, one clock after the inputs they depend on. A change of input between edges does not show on the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_pos | input | 8 | Bit position in frame, 0 = framing bit, 1..192 = payload |
| frame_num | input | 5 | Frame number in multiframe, 0-based |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame D4 |
| link_sel | input | 1 | 1 = link clock mode, 0 = channel clock mode |
| half_rate | input | 1 | 1 = 2 kHz link clock in 24-frame mode |
| chan_mask | input | 24 | Per-channel marker value, bit n for channel n+1 |
| out_clk | output | 1 | Channel clock or link clock |
| out_blk | output | 1 | Channel marker or pre-link-frame flag |
| link_stb | output | 1 | Link bit sample strobe |

## Verification
The embedded assertions watch, on every cycle, the properties that tie a single input value to the next output. These are: the clock pulse after position 8, the quiet outputs after the framing bit and after an out-of-range position, the absence of a link strobe in channel mode, and the rule that a link strobe always follows position 0 in link mode. The directed scenarios are needed for the rest. Only they can show the full mask mapping under several patterns, the frame selection for each of the three link rates, the wrap of the pre-frame flag at the end of each multiframe length, and the one-clock latency seen between edges.

// File: rtl/t1_slot_pkg.sv
package t1_slot_pkg;

    localparam int SLOT_CHANNELS   = 24;
    localparam int SLOT_CH_BITS    = 8;
    localparam int SLOT_ESF_FRAMES = 24;
    localparam int SLOT_D4_FRAMES  = 12;

    // registered output bundle
    typedef struct packed {
        logic clk_o;
        logic blk_o;
        logic stb_o;
    } slot_out_t;

endpackage

// File: rtl/t1_chan_decode.sv
module t1_chan_decode #(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    parameter int POS_W    = $clog2(CHANNELS * CH_BITS + 1)
) (
    input  logic [POS_W-1:0]    bit_pos,
    input  logic [CHANNELS-1:0] chan_mask,
    output logic                lsb_hit,
    output logic                blk_val
);
    localparam int PAYLOAD_BITS = CHANNELS * CH_BITS;
    localparam int CH_W         = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
    localparam int PAD          = 1 << CH_W;
    localparam int SUB_W        = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;
    localparam bit POW2         = ((CH_BITS & (CH_BITS - 1)) == 0) && (CH_BITS > 1);

    logic             in_payload;
    logic [POS_W-1:0] offs;
    logic [CH_W-1:0]  idx;
    logic             last_bit;
    logic [PAD-1:0]   mask_pad;

    assign in_payload = (bit_pos != '0) && (32'(bit_pos) <= PAYLOAD_BITS);
    assign offs       = bit_pos - POS_W'(1);
    assign mask_pad   = PAD'(chan_mask);

    // channel index and last-bit detection: shift/slice when the channel
    // width is a power of two, divide otherwise
    generate
        if (POW2) begin : g_slice
            assign idx      = CH_W'(offs >> SUB_W);
            assign last_bit = (offs[SUB_W-1:0] == SUB_W'(CH_BITS - 1));
        end else begin : g_divide
            assign idx      = CH_W'(offs / POS_W'(CH_BITS));
            assign last_bit = ((offs % POS_W'(CH_BITS)) == POS_W'(CH_BITS - 1));
        end
    endgenerate

    assign lsb_hit = in_payload && last_bit;
    assign blk_val = in_payload && mask_pad[idx];

endmodule

// File: rtl/t1_link_decode.sv
module t1_link_decode #(
    parameter int ESF_FRAMES = 24,
    parameter int D4_FRAMES  = 12,
    parameter int FRAME_BITS = 193,
    parameter int POS_W      = $clog2(FRAME_BITS),
    parameter int FRM_W      = $clog2(ESF_FRAMES)
) (
    input  logic [POS_W-1:0] bit_pos,
    input  logic [FRM_W-1:0] frame_num,
    input  logic             esf_mode,
    input  logic             half_rate,
    output logic             clk_val,
    output logic             stb_val,
    output logic             pre_val
);
    localparam int              HALF_POS = FRAME_BITS / 2;
    localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);
    localparam logic [FRM_W-1:0] D4_LAST  = FRM_W'(D4_FRAMES - 1);

    logic [FRM_W-1:0] last_frame;
    logic [FRM_W-1:0] next_frame;
    logic             frame_ok;
    logic             pos_ok;
    logic             cur_link;
    logic             nxt_link;

    // which frames carry an overhead link bit for the selected rate
    function automatic logic carries_link(input logic [FRM_W-1:0] f,
                                          input logic esf, input logic half);
        if (esf) begin
            carries_link = half ? (f[1:0] == 2'b00) : !f[0];
        end else begin
            carries_link = f[0];
        end
    endfunction

    always_comb begin
        last_frame = esf_mode ? ESF_LAST : D4_LAST;
        frame_ok   = (frame_num <= last_frame);
        pos_ok     = (32'(bit_pos) < FRAME_BITS);
        next_frame = (frame_num == last_frame) ? '0 : frame_num + FRM_W'(1);
        cur_link   = carries_link(frame_num, esf_mode, half_rate);
        nxt_link   = carries_link(next_frame, esf_mode, half_rate);
        clk_val    = frame_ok && pos_ok && cur_link && (32'(bit_pos) < HALF_POS);
        stb_val    = frame_ok && cur_link && (bit_pos == '0);
        pre_val    = frame_ok && nxt_link && (32'(bit_pos) == FRAME_BITS - 1);
    end

endmodule

// File: rtl/t1_slot_timer.sv
module t1_slot_timer
    import t1_slot_pkg::*;
#(
    parameter int CHANNELS   = SLOT_CHANNELS,
    parameter int CH_BITS    = SLOT_CH_BITS,
    parameter int ESF_FRAMES = SLOT_ESF_FRAMES,
    parameter int D4_FRAMES  = SLOT_D4_FRAMES,
    localparam int FRAME_BITS = CHANNELS * CH_BITS + 1,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int FRM_W      = $clog2(ESF_FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [POS_W-1:0]    bit_pos,
    input  logic [FRM_W-1:0]    frame_num,
    input  logic                esf_mode,
    input  logic                link_sel,
    input  logic                half_rate,
    input  logic [CHANNELS-1:0] chan_mask,
    output logic                out_clk,
    output logic                out_blk,
    output logic                link_stb
);
    logic      ch_lsb, ch_blk;
    logic      lk_clk, lk_stb, lk_pre;
    slot_out_t out_d, out_q;

    t1_chan_decode #(
        .CHANNELS (CHANNELS),
        .CH_BITS  (CH_BITS),
        .POS_W    (POS_W)
    ) u_chan (
        .bit_pos   (bit_pos),
        .chan_mask (chan_mask),
        .lsb_hit   (ch_lsb),
        .blk_val   (ch_blk)
    );

    t1_link_decode #(
        .ESF_FRAMES (ESF_FRAMES),
        .D4_FRAMES  (D4_FRAMES),
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W),
        .FRM_W      (FRM_W)
    ) u_link (
        .bit_pos   (bit_pos),
        .frame_num (frame_num),
        .esf_mode  (esf_mode),
        .half_rate (half_rate),
        .clk_val   (lk_clk),
        .stb_val   (lk_stb),
        .pre_val   (lk_pre)
    );

    // shared-pin selection
    always_comb begin
        out_d = '0;
        if (link_sel) begin
            out_d.clk_o = lk_clk;
            out_d.blk_o = lk_pre;
            out_d.stb_o = lk_stb;
        end else begin
            out_d.clk_o = ch_lsb;
            out_d.blk_o = ch_blk;
            out_d.stb_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_clk  = out_q.clk_o;
    assign out_blk  = out_q.blk_o;
    assign link_stb = out_q.stb_o;

    assert_lsb_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_sel && bit_pos == POS_W'(CH_BITS)) |=> out_clk);

    assert_framing_bit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_sel && bit_pos == '0) |=> (!out_clk && !out_blk));

    assert_no_stb_in_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !link_sel |=> !link_stb);

    assert_stb_at_frame_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_stb |-> ($past(bit_pos) == '0 && $past(link_sel)));

    assert_range_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bit_pos) >= FRAME_BITS) |=> (!out_clk && !out_blk && !link_stb));

endmodule

// File: tb/t1_slot_timer_bench.sv
`timescale 1ns/1ps
module t1_slot_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bit_pos = '0;
    logic [4:0]  frame_num = '0;
    logic        esf_mode = 1'b1;
    logic        link_sel = 1'b0;
    logic        half_rate = 1'b0;
    logic [23:0] chan_mask = '0;
    logic        out_clk, out_blk, link_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    t1_slot_timer u_t1_slot_timer (
        .clk(clk), .rst_n(rst_n), .bit_pos(bit_pos), .frame_num(frame_num),
        .esf_mode(esf_mode), .link_sel(link_sel), .half_rate(half_rate),
        .chan_mask(chan_mask), .out_clk(out_clk), .out_blk(out_blk),
        .link_stb(link_stb)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (bit_pos=%0d frame=%0d link=%b esf=%b half=%b)",
                     tag, got, exp, bit_pos, frame_num, link_sel, esf_mode, half_rate);
        end
    endtask

    function automatic bit link_frame(input int f, input bit esf, input bit half);
        if (esf) return half ? (f % 4 == 0) : (f % 2 == 0);
        return (f % 2 == 1);
    endfunction

    // expected outputs from the requirements: {clk, blk, stb}
    function automatic logic [2:0] model(input int bp, input int fn);
        int  nfr;
        bit  c, b, s;
        int  nframes;
        c = 0; b = 0; s = 0;
        if (!link_sel) begin
            if (bp >= 1 && bp <= 192) begin
                c = (bp % 8 == 0);
                b = chan_mask[(bp - 1) / 8];
            end
        end else begin
            nframes = esf_mode ? 24 : 12;
            if (fn < nframes) begin
                nfr = (fn == nframes - 1) ? 0 : fn + 1;
                c = link_frame(fn, esf_mode, half_rate) && bp < 96;
                s = link_frame(fn, esf_mode, half_rate) && bp == 0;
                b = link_frame(nfr, esf_mode, half_rate) && bp == 192;
            end
        end
        return {c, b, s};
    endfunction

    task automatic apply(input int bp, input int fn,
                         input string tc, input string tb, input string ts);
        logic [2:0] e;
        @(negedge clk);
        bit_pos   = 8'(bp);
        frame_num = 5'(fn);
        e = model(bp, fn);
        @(posedge clk);
        #1;
        chk(tc, out_clk, e[2]);
        chk(tb, out_blk, e[1]);
        chk(ts, link_stb, e[0]);
    endtask

    task automatic t_reset_R1();
        @(negedge clk);
        rst_n = 1'b0;
        link_sel = 1'b0;
        chan_mask = '1;
        bit_pos = 8'd8;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 clk", out_clk, 1'b0);
        chk("R1 blk", out_blk, 1'b0);
        chk("R1 stb", link_stb, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_channel_sweep(input logic [23:0] m);
        link_sel = 1'b0;
        chan_mask = m;
        for (int p = 0; p <= 192; p++) apply(p, 0, "R2", "R3", "R4");
    endtask

    task automatic t_link_sweep(input bit esf, input bit half, input string tag);
        int nf;
        link_sel = 1'b1;
        esf_mode = esf;
        half_rate = half;
        nf = esf ? 24 : 12;
        for (int f = 0; f < nf; f++) begin
            apply(0, f, tag, "R9", "R8");
            apply(50, f, tag, "R9", "R8");
            apply(95, f, tag, "R9", "R8");
            apply(96, f, tag, "R9", "R8");
            apply(192, f, tag, "R9", "R8");
        end
    endtask

    task automatic t_wrap_R9();
        link_sel = 1'b1;
        esf_mode = 1'b1; half_rate = 1'b0;
        apply(192, 23, "R9 clk", "R9 wrap esf", "R9 stb");
        chk("R9 esf 23->0", out_blk, 1'b1);
        esf_mode = 1'b0;
        apply(192, 11, "R9 clk", "R9 wrap d4", "R9 stb");
        chk("R9 d4 11->0", out_blk, 1'b0);
        apply(192, 10, "R9 clk", "R9 d4 10", "R9 stb");
        chk("R9 d4 10->11", out_blk, 1'b1);
    endtask

    task automatic t_range_R10();
        link_sel = 1'b0; chan_mask = '1;
        apply(193, 0, "R10", "R10", "R10");
        apply(255, 0, "R10", "R10", "R10");
        link_sel = 1'b1; esf_mode = 1'b1; half_rate = 1'b0;
        apply(200, 0, "R10", "R10", "R10");
        apply(0, 24, "R10", "R10", "R10");
        apply(0, 30, "R10", "R10", "R10");
        esf_mode = 1'b0;
        apply(0, 13, "R10", "R10", "R10");
        apply(192, 12, "R10", "R10", "R10");
    endtask

    task automatic t_latency_R11();
        link_sel = 1'b0; chan_mask = '0;
        apply(7, 0, "R11", "R11", "R11");
        @(negedge clk);
        bit_pos = 8'd8;
        #1;
        chk("R11 before edge", out_clk, 1'b0);
        @(posedge clk);
        #1;
        chk("R11 after edge", out_clk, 1'b1);
        @(negedge clk);
        link_sel = 1'b1; esf_mode = 1'b1; half_rate = 1'b0;
        bit_pos = 8'd0; frame_num = 5'd0;
        #1;
        chk("R11 mode held", link_stb, 1'b0);
        @(posedge clk);
        #1;
        chk("R11 mode switched", link_stb, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_R1();
        t_channel_sweep(24'hA5C3F0);
        t_channel_sweep(24'h000001);
        t_channel_sweep(24'h800000);
        t_link_sweep(1'b1, 1'b0, "R5");
        t_link_sweep(1'b1, 1'b1, "R6");
        t_link_sweep(1'b0, 1'b0, "R7");
        t_link_sweep(1'b0, 1'b1, "R7");
        t_wrap_R9();
        t_range_R10();
        t_latency_R11();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule